// File: doc/BRIEF.md
# Striped Multi-Lane Vector Add/Multiply Unit

This block executes one vector arithmetic instruction at a time, either an add or a multiply, over a vector of up to 32 elements of 64 bits. The work is spread over 8 parallel lanes. Element `i` always belongs to lane `i mod 8`, so one lane sees elements `i`, `i+8`, `i+16` and `i+24` in that order. Each lane holds its own pipelined arithmetic unit. The add path takes 1 cycle and the multiply path takes 6 cycles.

Every 64-bit element slot can be treated as one 64-bit value, four 16-bit values or eight 8-bit values. The instruction selects the view. No carry crosses the boundary between two packed values. The second operand can be a vector or a broadcast scalar, and the first operand can also be the scalar.

A sequencer issues one group of 8 element positions per cycle. It issues only the positions below the active vector length, then waits for the pipeline to drain and pulses `done`. Each result leaves the block on its lane with a valid strobe and its element index. The valid strobe doubles as the write enable for the result.

Top module: `vec_lane_alu`

## Requirements
- R1: After reset, `busy`, `done` and every bit of `wb_valid` are 0.
- R2: The result for element `i` appears only on lane `i mod 8`, with `wb_idx` equal to `i`. The lowest 3 bits of the index therefore equal the lane number.
- R3: `op`=0 selects an add. `ew` selects the element view: 0 is one 64-bit value, 1 is four 16-bit values at bits [16k+15:16k], 2 is eight 8-bit values at bits [8k+7:8k], and 3 behaves as 0. Each packed value wraps modulo 2^width, with no carry into its neighbour.
- R4: `op`=1 selects a multiply. Each packed value of the result is the low `width` bits of the product of the two matching packed operand values.
- R5: `form` selects the operands. 0 means both come from the vectors (`src_a`, `src_b`). 1 means the second operand is `scalar`. 2 means the first operand is `scalar`. 3 behaves as 0. Element `i` of a vector is `src_a[64i+63:64i]` (and the same for `src_b`).
- R6: Only elements with index below the active length produce a valid result. The active length is `vl`, except that any `vl` above 32 counts as 32.
- R7: Let E0 be the clock edge that accepts `start`, and let k be a group number. The results for group k (elements 8k to 8k+7) are on the outputs for the one cycle after edge E(k+1) for an add, and after edge E(k+6) for a multiply. Within a lane, the indices come out in increasing order.
- R8: `busy` is high from E0 until `done` rises. `done` is a one-cycle pulse in the cycle after the last result. With n = ceil(length/8), that is after edge E(n+1) for an add and after E(n+6) for a multiply. A zero length gives `done` after E1 with no valid results.
- R9: A `start` while `busy` is high is ignored. The instruction in flight keeps the `op`, `form`, `ew`, `vl` and `scalar` it captured at E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an instruction; taken only while idle |
| op | input | 1 | 0 = add, 1 = multiply |
| form | input | 2 | Operand form: 0 = vector-vector, 1 = vector-scalar, 2 = scalar-vector |
| ew | input | 2 | Element view: 0 = 64-bit, 1 = 16-bit, 2 = 8-bit |
| vl | input | 6 | Active vector length (values above 32 count as 32) |
| scalar | input | 64 | Broadcast scalar operand |
| src_a | input | 2048 | First source vector; must stay stable while busy |
| src_b | input | 2048 | Second source vector; must stay stable while busy |
| busy | output | 1 | An instruction is in flight |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 8 | Per-lane result valid, used as the write enable |
| wb_idx | output | 40 | Per-lane element index, 5 bits per lane |
| wb_data | output | 512 | Per-lane result data, 64 bits per lane |

## Verification
The bench drives operands made of all-ones bytes and halfwords against ones, in the 8-bit and 16-bit views. A datapath that let a carry cross a packed boundary would corrupt the neighbouring value instead of wrapping it to zero.

It runs lengths of 0, 1, 9 and 45. A design that issues whole groups, mishandles the clamp, or waits for a last group that does not exist would raise stray valids or pulse `done` in the wrong cycle.

It compares the vector-scalar and scalar-vector forms with different vector contents. A swapped scalar position would then take its data from the wrong source vector.

A second `start` is raised in the middle of a multiply, with changed control inputs. A sequencer that re-captured the controls would change the results, the length or the latency of the instruction in flight.

// File: rtl/vla_pkg.sv
package vla_pkg;

  typedef enum logic [1:0] {
    EW_D64 = 2'd0,
    EW_H16 = 2'd1,
    EW_B8  = 2'd2,
    EW_RSV = 2'd3
  } elem_w_e;

  typedef enum logic [1:0] {
    FM_VV  = 2'd0,
    FM_VS  = 2'd1,
    FM_SV  = 2'd2,
    FM_RSV = 2'd3
  } opnd_form_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_e;

endpackage

// File: rtl/vla_simd_unit.sv
module vla_simd_unit
  import vla_pkg::*;
#(
  parameter int ELEN = 64
) (
  input  logic            mul,
  input  elem_w_e         ew,
  input  logic [ELEN-1:0] a,
  input  logic [ELEN-1:0] b,
  output logic [ELEN-1:0] y
);

  localparam int N16 = ELEN / 16;
  localparam int N8  = ELEN / 8;

  logic [ELEN-1:0] y64;
  logic [ELEN-1:0] y16;
  logic [ELEN-1:0] y8;

  // full-width view
  assign y64 = mul ? a * b : a + b;

  // 16-bit view: every slice is an isolated adder or multiplier
  for (genvar k = 0; k < N16; k++) begin : g_h16
    assign y16[k*16 +: 16] = mul ? a[k*16 +: 16] * b[k*16 +: 16]
                                 : a[k*16 +: 16] + b[k*16 +: 16];
  end

  // 8-bit view
  for (genvar k = 0; k < N8; k++) begin : g_b8
    assign y8[k*8 +: 8] = mul ? a[k*8 +: 8] * b[k*8 +: 8]
                              : a[k*8 +: 8] + b[k*8 +: 8];
  end

  always_comb begin
    case (ew)
      EW_H16:  y = y16;
      EW_B8:   y = y8;
      default: y = y64;
    endcase
  end

endmodule

// File: rtl/vla_lane.sv
module vla_lane
  import vla_pkg::*;
#(
  parameter int ELEN    = 64,
  parameter int IDXW    = 5,
  parameter int LANES   = 8,
  parameter int LANE    = 0,
  parameter int MUL_LAT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_v,
  input  logic [IDXW-1:0] iss_idx,
  input  logic            mul,
  input  elem_w_e         ew,
  input  logic [ELEN-1:0] opa,
  input  logic [ELEN-1:0] opb,
  output logic            wb_v,
  output logic [IDXW-1:0] wb_idx,
  output logic [ELEN-1:0] wb_data
);

  logic [ELEN-1:0]    res;
  logic [MUL_LAT-1:0] v_q, v_d, en;
  logic [IDXW-1:0]    i_q [MUL_LAT];
  logic [IDXW-1:0]    i_d [MUL_LAT];
  logic [ELEN-1:0]    d_q [MUL_LAT];
  logic [ELEN-1:0]    d_d [MUL_LAT];

  vla_simd_unit #(.ELEN(ELEN)) u_simd (
    .mul (mul),
    .ew  (ew),
    .a   (opa),
    .b   (opb),
    .y   (res)
  );

  // next-state of the result pipeline; stage 0 is the add tap, the
  // deeper stages only receive entries when a multiply is running
  always_comb begin
    v_d[0] = iss_v;
    i_d[0] = iss_idx;
    d_d[0] = res;
    for (int s = 1; s < MUL_LAT; s++) begin
      v_d[s] = v_q[s-1] & ((s != 1) | mul);
      i_d[s] = i_q[s-1];
      d_d[s] = d_q[s-1];
    end
    en = v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < MUL_LAT; s++) begin
      if (en[s]) begin
        i_q[s] <= i_d[s];
        d_q[s] <= d_d[s];
      end
    end
  end

  assign wb_v    = mul ? v_q[MUL_LAT-1] : v_q[0];
  assign wb_idx  = mul ? i_q[MUL_LAT-1] : i_q[0];
  assign wb_data = mul ? d_q[MUL_LAT-1] : d_q[0];

  // R2: a lane only ever emits element positions it owns
  p_lane_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_v |-> ((wb_idx % IDXW'(LANES)) == IDXW'(LANE)));

  // R7: back-to-back results of one lane step by the lane count
  p_lane_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_v && $past(wb_v)) |-> (wb_idx == ($past(wb_idx) + IDXW'(LANES))));

endmodule

// File: rtl/vla_seq.sv
module vla_seq
  import vla_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int VLMAX   = 32,
  parameter int MUL_LAT = 6,
  parameter int VLW     = $clog2(VLMAX + 1),
  parameter int GRPW    = $clog2(VLMAX / LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl_in,
  input  logic            mul,
  output logic            busy,
  output logic            done,
  output logic            start_acc,
  output logic            issue,
  output logic [GRPW-1:0] grp,
  output logic [VLW-1:0]  vlc
);

  localparam int LW   = $clog2(LANES);
  localparam int CNTW = $clog2(MUL_LAT);

  seq_state_e      st_q, st_d;
  logic [GRPW-1:0] grp_q, grp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [VLW-1:0]  vlc_q, vlc_d;
  logic            done_q, done_d;
  logic [VLW-1:0]  vl_clamp;
  logic [GRPW-1:0] last_grp;

  assign vl_clamp = (vl_in > VLW'(VLMAX)) ? VLW'(VLMAX) : vl_in;
  assign last_grp = GRPW'((vlc_q - VLW'(1)) >> LW);

  always_comb begin
    st_d      = st_q;
    grp_d     = grp_q;
    cnt_d     = cnt_q;
    vlc_d     = vlc_q;
    done_d    = 1'b0;
    start_acc = 1'b0;
    issue     = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          start_acc = 1'b1;
          vlc_d     = vl_clamp;
          grp_d     = '0;
          cnt_d     = '0;
          st_d      = (vl_clamp == '0) ? SQ_DRAIN : SQ_ISSUE;
        end
      end
      SQ_ISSUE: begin
        issue = 1'b1;
        if (grp_q == last_grp) begin
          st_d  = SQ_DRAIN;
          cnt_d = mul ? CNTW'(MUL_LAT - 1) : '0;
        end else begin
          grp_d = grp_q + 1'b1;
        end
      end
      SQ_DRAIN: begin
        if (cnt_q == '0) begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      grp_q  <= '0;
      cnt_q  <= '0;
      vlc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      grp_q  <= grp_d;
      cnt_q  <= cnt_d;
      vlc_q  <= vlc_d;
      done_q <= done_d;
    end
  end

  assign busy = (st_q != SQ_IDLE);
  assign done = done_q;
  assign grp  = grp_q;
  assign vlc  = vlc_q;

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: no group starting at or past the active length is issued
  p_issue_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (VLW'({grp_q, {LW{1'b0}}}) < vlc_q));

  // R9: a request during an instruction leaves its length untouched
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vlc_q));

endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
  import vla_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int VLMAX   = 32,
  parameter int ELEN    = 64,
  parameter int MUL_LAT = 6,
  parameter int VLW     = $clog2(VLMAX + 1),
  parameter int IDXW    = $clog2(VLMAX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    op,
  input  logic [1:0]              form,
  input  logic [1:0]              ew,
  input  logic [VLW-1:0]          vl,
  input  logic [ELEN-1:0]         scalar,
  input  logic [VLMAX*ELEN-1:0]   src_a,
  input  logic [VLMAX*ELEN-1:0]   src_b,
  output logic                    busy,
  output logic                    done,
  output logic [LANES-1:0]        wb_valid,
  output logic [LANES*IDXW-1:0]   wb_idx,
  output logic [LANES*ELEN-1:0]   wb_data
);

  localparam int LW   = $clog2(LANES);
  localparam int GRPW = IDXW - LW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  // instruction controls, captured once per instruction
  logic            start_acc, issue;
  logic [GRPW-1:0] grp;
  logic [VLW-1:0]  vlc;
  logic            mul_q;
  opnd_form_e      form_q;
  elem_w_e         ew_q;
  logic [ELEN-1:0] scalar_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)        mul_q <= 1'b0;
    else if (start_acc) mul_q <= op;
  end

  always_ff @(posedge clk) begin
    if (start_acc) begin
      form_q   <= opnd_form_e'(form);
      ew_q     <= elem_w_e'(ew);
      scalar_q <= scalar;
    end
  end

  vla_seq #(
    .LANES   (LANES),
    .VLMAX   (VLMAX),
    .MUL_LAT (MUL_LAT),
    .VLW     (VLW),
    .GRPW    (GRPW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .start     (start),
    .vl_in     (vl),
    .mul       (mul_q),
    .busy      (busy),
    .done      (done),
    .start_acc (start_acc),
    .issue     (issue),
    .grp       (grp),
    .vlc       (vlc)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDXW-1:0] idx;
    logic            iv;
    logic [ELEN-1:0] ea, eb, opa, opb;

    assign idx = {grp, LW'(l)};
    assign iv  = issue && (VLW'(idx) < vlc);
    assign ea  = src_a[idx*ELEN +: ELEN];
    assign eb  = src_b[idx*ELEN +: ELEN];
    assign opa = (form_q == FM_SV) ? scalar_q : ea;
    assign opb = (form_q == FM_VS) ? scalar_q : eb;

    vla_lane #(
      .ELEN    (ELEN),
      .IDXW    (IDXW),
      .LANES   (LANES),
      .LANE    (l),
      .MUL_LAT (MUL_LAT)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_ns),
      .iss_v   (iv),
      .iss_idx (idx),
      .mul     (mul_q),
      .ew      (ew_q),
      .opa     (opa),
      .opb     (opb),
      .wb_v    (wb_valid[l]),
      .wb_idx  (wb_idx[l*IDXW +: IDXW]),
      .wb_data (wb_data[l*ELEN +: ELEN])
    );

    // R6: results leave only for positions under the captured length
    p_valid_below_vl_r6: assert property (@(posedge clk) disable iff (!rst_ns)
      wb_valid[l] |-> (VLW'(wb_idx[l*IDXW +: IDXW]) < vlc));
  end

  // R8: nothing is written back while no instruction is in flight
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> (wb_valid == '0));

endmodule

// File: tb/test_vec_lane_alu.sv
module test_vec_lane_alu;

  localparam int L = 8;
  localparam int N = 32;
  localparam int E = 64;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i, op_i;
  logic [1:0]     form_i, ew_i;
  logic [5:0]     vl_i;
  logic [E-1:0]   scalar_i;
  logic [N*E-1:0] src_a, src_b;
  logic           busy_o, done_o;
  logic [L-1:0]   wbv;
  logic [L*5-1:0] wbi;
  logic [L*E-1:0] wbd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vec_lane_alu i_vec_lane_alu (
    .clk(clk), .rst_n(rst_n), .start(start_i), .op(op_i), .form(form_i),
    .ew(ew_i), .vl(vl_i), .scalar(scalar_i), .src_a(src_a), .src_b(src_b),
    .busy(busy_o), .done(done_o), .wb_valid(wbv), .wb_idx(wbi), .wb_data(wbd)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_alu(input bit mul, input logic [1:0] ew,
                                          input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    if (ew == 2'd1) begin
      for (int k = 0; k < 4; k++)
        r[k*16 +: 16] = mul ? 16'(a[k*16 +: 16] * b[k*16 +: 16])
                            : 16'(a[k*16 +: 16] + b[k*16 +: 16]);
    end else if (ew == 2'd2) begin
      for (int k = 0; k < 8; k++)
        r[k*8 +: 8] = mul ? 8'(a[k*8 +: 8] * b[k*8 +: 8])
                          : 8'(a[k*8 +: 8] + b[k*8 +: 8]);
    end else begin
      r = mul ? a * b : a + b;
    end
    return r;
  endfunction

  task automatic fill_rand();
    for (int j = 0; j < N*E/32; j++) begin
      src_a[j*32 +: 32] = $urandom;
      src_b[j*32 +: 32] = $urandom;
    end
  endtask

  task automatic run_op(input bit mul, input logic [1:0] fm, input logic [1:0] ew,
                        input int vl, input bit inject);
    int vlc    = (vl > N) ? N : vl;
    int lat    = mul ? 6 : 1;
    int ng     = (vlc + L - 1) / L;
    int done_m = (vlc == 0) ? 1 : ng + lat;
    logic [63:0] sc = {$urandom, $urandom};
    string dtag = inject ? "R9" : (mul ? "R4" : ((fm == 2'd1 || fm == 2'd2) ? "R5" : "R3"));
    string vtag = (vlc < N) ? "R6" : "R7";
    @(negedge clk);
    op_i = mul; form_i = fm; ew_i = ew; vl_i = 6'(vl); scalar_i = sc; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int m = 1; m <= done_m; m++) begin
      @(posedge clk);
      @(negedge clk);
      chk(done_o == (m == done_m), "R8", 64'(done_o), 64'(m == done_m));
      chk(busy_o == (m < done_m), "R8", 64'(busy_o), 64'(m < done_m));
      for (int l = 0; l < L; l++) begin
        int  k  = m - lat;
        int  i  = k * L + l;
        bit  ev = (k >= 0) && (k < N / L) && (i < vlc);
        chk(wbv[l] == ev, vtag, 64'(wbv[l]), 64'(ev));
        if (ev && wbv[l]) begin
          logic [63:0] a = (fm == 2'd2) ? sc : src_a[i*E +: E];
          logic [63:0] b = (fm == 2'd1) ? sc : src_b[i*E +: E];
          chk(wbi[l*5 +: 5] == 5'(i), "R2", 64'(wbi[l*5 +: 5]), 64'(i));
          chk(wbd[l*E +: E] == ref_alu(mul, ew, a, b), dtag,
              wbd[l*E +: E], ref_alu(mul, ew, a, b));
        end
      end
      if (inject && m == 1 && done_m >= 3) begin
        start_i = 1'b1; op_i = ~mul; vl_i = 6'd3; form_i = fm ^ 2'd1;
        ew_i = ew ^ 2'd1; scalar_i = ~sc;
      end else begin
        start_i = 1'b0;
      end
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0C4B);
    rst_n = 1'b0; start_i = 1'b0; op_i = 1'b0; form_i = 2'd0; ew_i = 2'd0;
    vl_i = '0; scalar_i = '0; src_a = '0; src_b = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0, "R1", 64'(busy_o), 64'd0);
    chk(done_o == 1'b0, "R1", 64'(done_o), 64'd0);
    chk(wbv == '0, "R1", 64'(wbv), 64'd0);

    // R3 carry isolation: all-ones plus one wraps each packed value to zero
    src_a = '1;
    for (int j = 0; j < N*E/8; j++) src_b[j*8 +: 8] = 8'h01;
    run_op(1'b0, 2'd0, 2'd2, 32, 1'b0);
    for (int j = 0; j < N*E/16; j++) src_b[j*16 +: 16] = 16'h0001;
    run_op(1'b0, 2'd0, 2'd1, 32, 1'b0);
    run_op(1'b0, 2'd0, 2'd3, 32, 1'b0);

    // R6 and R8 length corners
    fill_rand();
    run_op(1'b1, 2'd0, 2'd0, 0, 1'b0);
    run_op(1'b0, 2'd0, 2'd0, 0, 1'b0);
    run_op(1'b0, 2'd2, 2'd0, 1, 1'b0);
    run_op(1'b1, 2'd1, 2'd1, 9, 1'b0);
    run_op(1'b0, 2'd0, 2'd2, 45, 1'b0);
    run_op(1'b1, 2'd0, 2'd0, 63, 1'b0);

    // R5 the two scalar positions over the same vectors
    run_op(1'b0, 2'd1, 2'd0, 32, 1'b0);
    run_op(1'b0, 2'd2, 2'd0, 32, 1'b0);
    run_op(1'b1, 2'd2, 2'd2, 20, 1'b0);
    run_op(1'b0, 2'd3, 2'd1, 17, 1'b0);

    // R9 start during an instruction
    run_op(1'b1, 2'd0, 2'd1, 32, 1'b1);
    run_op(1'b0, 2'd1, 2'd0, 24, 1'b1);

    // random mix
    for (int t = 0; t < 40; t++) begin
      fill_rand();
      run_op(1'($urandom), 2'($urandom), 2'($urandom), int'($urandom % 40), 1'($urandom));
    end

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(busy_o == 1'b0 && wbv == '0, "R8", {wbv, busy_o}, 64'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule